// File: doc/BRIEF.md
# Double-Buffered DAC Code Latch Controller

This block is the digital front end of a 14-bit converter. It holds two registers in series. A staging register takes words from a 14-bit parallel bus. A code register drives the converter. Three active-low control pins decide when each register loads: a chip enable (`sel_n`), a write strobe (`wstb_n`) and a transfer control (`xfer_n`). The pins arrive asynchronously. The block runs them through a two-flop synchronizer on a fast system clock. It then turns their level-transparent behaviour into synchronous load enables. The bus is delayed by a matching amount so that data and controls stay aligned.

A three-state machine decides which register is open. The states are:
- `ST_HOLD`: both registers hold.
- `ST_IN_OPEN`: the staging register follows the bus.
- `ST_DAC_OPEN`: the code register follows the staging register.

The two registers are never open together. Because of this, a system that ties `xfer_n` low still gets one clean update each time a write closes. When `xfer_n` is pulsed instead, the update follows its falling edge.

The named transitions are:
- WRITE_BEGIN: from any state to `ST_IN_OPEN`, when `sel_n` and `wstb_n` are both low.
- WRITE_END_XFER: from `ST_IN_OPEN` to `ST_DAC_OPEN`, when the write closes while `xfer_n` is low.
- WRITE_END_HOLD: from `ST_IN_OPEN` to `ST_HOLD`, when the write closes while `xfer_n` is high.
- XFER_FALL: from `ST_HOLD` to `ST_DAC_OPEN`.
- XFER_RISE: from `ST_DAC_OPEN` to `ST_HOLD`.

Top module: `dac_latch_ctrl`

## Requirements
- R1: Synchronous reset clears the staging register and the code register to zero, and `upd_pulse` is low.
- R2: The staging register follows the bus while `sel_n` and `wstb_n` are both low. It keeps the last word seen before either pin rises.
- R3: While `xfer_n` is high and no write is open, neither register changes and `upd_pulse` stays low.
- R4: A falling `xfer_n` after a write copies the staging word into `dac_code`. The new value appears on the 4th rising clock edge after the pin change.
- R5: While `sel_n`, `wstb_n` and `xfer_n` are all low, `dac_code` does not change, whatever the bus does.
- R6: With `xfer_n` held low, the rise of `sel_n` or of `wstb_n` puts the captured word on `dac_code`. This happens on the 4th rising edge after the rise.
- R7: `upd_pulse` is high for exactly one cycle, in the cycle where `dac_code` takes a new value. It does not fire when a transfer copies an equal word.
- R8: Codes are 14-bit two's complement and are passed bit-exact: 0x1FFF is positive full scale, 0x2000 is negative full scale, 0x0000 is midscale.
- R9: Only one of `sel_n` and `wstb_n` being low does not open the staging register. Bus changes made then never reach `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Chip enable, active low, asynchronous |
| wstb_n | input | 1 | Write strobe, active low, asynchronous |
| xfer_n | input | 1 | Staging-to-code transfer control, active low, asynchronous |
| bus_data | input | 14 | Parallel data word, bit 13 is the sign bit |
| dac_code | output | 14 | Code register contents driving the converter |
| upd_pulse | output | 1 | One-cycle pulse when `dac_code` changes |

## Verification
Every pin change passes through three clock edges before the state register acts on it: two synchronizer stages and the state register. The code register then loads on the 4th rising edge. So `dac_code` is checked unchanged after three edges and at its new value after the fourth. The update pulse is due in the same cycle as the code change. A scoreboard queues each expected word when the driver causes a transfer, and the monitor pops it only when `upd_pulse` appears. An unexpected pulse, a pulse longer than one cycle, or a word still queued at the end all count as failures. All outputs are sampled on the falling clock edge, which is half a cycle clear of the edge that updates them.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    localparam int unsigned CODE_W      = 14;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_HOLD     = 2'd0,
        ST_IN_OPEN  = 2'd1,
        ST_DAC_OPEN = 2'd2
    } mode_e;
endpackage

// File: rtl/dlc_sync.sv
// Register chain: a metastability synchronizer for the control pins,
// and an alignment delay for the data bus.
module dlc_sync #(
    parameter int unsigned    W       = 1,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dlc_mode_fsm.sv
// Decides which register is open.
// Write-open has priority, so both registers are never open together.
module dlc_mode_fsm
    import dlc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_s_n,
    input  logic  wstb_s_n,
    input  logic  xfer_s_n,
    output logic  in_load,
    output logic  dac_load
);
    mode_e state, state_nx;
    logic  write_on;

    assign write_on = !sel_s_n && !wstb_s_n;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HOLD;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD: begin
                if (write_on)      state_nx = ST_IN_OPEN;   // WRITE_BEGIN
                else if (!xfer_s_n) state_nx = ST_DAC_OPEN; // XFER_FALL
            end
            ST_IN_OPEN: begin
                if (!write_on) begin
                    if (!xfer_s_n) state_nx = ST_DAC_OPEN;  // WRITE_END_XFER
                    else           state_nx = ST_HOLD;      // WRITE_END_HOLD
                end
            end
            ST_DAC_OPEN: begin
                if (write_on)      state_nx = ST_IN_OPEN;   // WRITE_BEGIN
                else if (xfer_s_n) state_nx = ST_HOLD;      // XFER_RISE
            end
            default: state_nx = ST_HOLD;
        endcase
    end

    always_comb begin
        in_load  = 1'b0;
        dac_load = 1'b0;
        unique case (state)
            ST_HOLD:     ;
            ST_IN_OPEN:  in_load  = 1'b1;
            ST_DAC_OPEN: dac_load = 1'b1;
            default:     ;
        endcase
    end

    // R2: an open write always reaches the input-open state next cycle
    assert_write_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (!sel_s_n && !wstb_s_n) |=> (state == ST_IN_OPEN));

    // R3: transfer high with no write leads to hold
    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (xfer_s_n && (sel_s_n || wstb_s_n)) |=> (state == ST_HOLD));

    // R9: a single low strobe never opens the staging register
    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        (sel_s_n ^ wstb_s_n) |=> (state != ST_IN_OPEN));
endmodule

// File: rtl/dlc_latch_pair.sv
// Staging and code registers, plus the change pulse.
module dlc_latch_pair #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_load,
    input  logic         dac_load,
    input  logic [W-1:0] data,
    output logic [W-1:0] code,
    output logic         upd
);
    logic [W-1:0] stage_q;
    logic [W-1:0] code_q;
    logic         upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            code_q  <= '0;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (in_load) stage_q <= data;
            if (dac_load) begin
                code_q <= stage_q;
                upd_q  <= (code_q != stage_q);
            end
        end
    end

    assign code = code_q;
    assign upd  = upd_q;

    // R5: transfers blocked while the staging register is open
    assert_blocked_R5: assert property (@(posedge clk) disable iff (rst)
        in_load |=> $stable(code_q));

    // R3: nothing moves when neither enable is active
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!in_load && !dac_load) |=> ($stable(code_q) && $stable(stage_q)));

    // R7: the pulse marks a real change
    assert_pulse_change_R7: assert property (@(posedge clk) disable iff (rst)
        upd_q |-> (code_q != $past(code_q)));

    // R7: every change is flagged
    assert_change_flagged_R7: assert property (@(posedge clk) disable iff (rst)
        (code_q != $past(code_q)) |-> upd_q);

    // R7: the pulse lasts one cycle
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
        upd_q |=> !upd_q);
endmodule

// File: rtl/dac_latch_ctrl.sv
module dac_latch_ctrl
    import dlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wstb_n,
    input  logic              xfer_n,
    input  logic [CODE_W-1:0] bus_data,
    output logic [CODE_W-1:0] dac_code,
    output logic              upd_pulse
);
    // Data follows the controls through the synchronizer and the state register.
    localparam int unsigned DATA_DLY = SYNC_STAGES + 1;

    logic [2:0]        ctl_s;
    logic [CODE_W-1:0] data_d;
    logic              in_load, dac_load;

    dlc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) i_ctl_sync (
        .clk (clk),
        .rst (rst),
        .d   ({xfer_n, wstb_n, sel_n}),
        .q   (ctl_s)
    );

    dlc_sync #(.W(CODE_W), .STAGES(DATA_DLY), .RST_VAL('0)) i_data_dly (
        .clk (clk),
        .rst (rst),
        .d   (bus_data),
        .q   (data_d)
    );

    dlc_mode_fsm i_fsm (
        .clk      (clk),
        .rst      (rst),
        .sel_s_n  (ctl_s[0]),
        .wstb_s_n (ctl_s[1]),
        .xfer_s_n (ctl_s[2]),
        .in_load  (in_load),
        .dac_load (dac_load)
    );

    dlc_latch_pair #(.W(CODE_W)) i_latches (
        .clk      (clk),
        .rst      (rst),
        .in_load  (in_load),
        .dac_load (dac_load),
        .data     (data_d),
        .code     (dac_code),
        .upd      (upd_pulse)
    );
endmodule

// File: tb/test_dac_latch_ctrl.sv
module test_dac_latch_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, wstb_n = 1'b1, xfer_n = 1'b1;
    logic [13:0] bus_data = '0;
    logic [13:0] dac_code;
    logic        upd_pulse;

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    logic [13:0] exp_q[$];
    string       tag_q[$];
    int          pulse_run = 0;

    always #4 clk = ~clk;

    dac_latch_ctrl i_dac_latch_ctrl (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wstb_n(wstb_n), .xfer_n(xfer_n),
        .bus_data(bus_data), .dac_code(dac_code), .upd_pulse(upd_pulse)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_word(input logic [13:0] w, input string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    // Monitor: pops the scoreboard on every update pulse (R7)
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (upd_pulse) begin
                pulse_run++;
                if (pulse_run > 1) check(1'b0, "R7 pulse width", pulse_run, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected pulse", int'(dac_code), 0);
                end else begin
                    automatic logic [13:0] w = exp_q.pop_front();
                    automatic string       t = tag_q.pop_front();
                    check(dac_code == w, t, int'(dac_code), int'(w));
                end
            end else begin
                pulse_run = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);
        // R1: reset state
        check(dac_code == 14'h0, "R1 code", int'(dac_code), 0);
        check(upd_pulse == 1'b0, "R1 pulse", int'(upd_pulse), 0);

        // R2 + R3: write with transfer high, bus changing while open
        xfer_n = 1'b1; sel_n = 1'b0; wstb_n = 1'b0; bus_data = 14'h0AAA;
        tick(2);
        bus_data = 14'h1234;
        tick(2);
        sel_n = 1'b1; bus_data = 14'h3FFF;          // sel_n rise captures 0x1234
        tick(2);
        wstb_n = 1'b1;
        tick(8);
        check(dac_code == 14'h0, "R3 hold", int'(dac_code), 0);

        // R4: transfer falling edge, due on 4th edge
        expect_word(14'h1234, "R2/R4 transfer word");
        xfer_n = 1'b0;
        tick(3);
        check(dac_code == 14'h0, "R4 early", int'(dac_code), 0);
        tick(1);
        check(dac_code == 14'h1234, "R4 due", int'(dac_code), 'h1234);
        tick(4);

        // R5 + R6: transfer held low, write open
        sel_n = 1'b0; wstb_n = 1'b0; bus_data = 14'h1FFF;
        tick(6);
        check(dac_code == 14'h1234, "R5 blocked", int'(dac_code), 'h1234);
        bus_data = 14'h0F0F;
        tick(2);
        check(dac_code == 14'h1234, "R5 blocked 2", int'(dac_code), 'h1234);
        expect_word(14'h0F0F, "R6 write end");
        wstb_n = 1'b1; bus_data = 14'h2000;        // wstb_n rise captures 0x0F0F
        tick(3);
        check(dac_code == 14'h1234, "R6 early", int'(dac_code), 'h1234);
        tick(1);
        check(dac_code == 14'h0F0F, "R6 due", int'(dac_code), 'h0F0F);
        sel_n = 1'b1;
        tick(4);

        // R8: negative full scale, then positive full scale
        sel_n = 1'b0; wstb_n = 1'b0; bus_data = 14'h2000;
        tick(2);
        expect_word(14'h2000, "R8 neg full scale");
        sel_n = 1'b1;
        tick(6);
        check(dac_code == 14'h2000, "R8 neg", int'(dac_code), 'h2000);
        wstb_n = 1'b1;
        tick(2);
        sel_n = 1'b0; wstb_n = 1'b0; bus_data = 14'h1FFF;
        tick(2);
        expect_word(14'h1FFF, "R8 pos full scale");
        wstb_n = 1'b1;
        tick(6);
        check(dac_code == 14'h1FFF, "R8 pos", int'(dac_code), 'h1FFF);
        sel_n = 1'b1;
        tick(2);

        // R7: rewrite the same word, no pulse expected
        sel_n = 1'b0; wstb_n = 1'b0; bus_data = 14'h1FFF;
        tick(3);
        sel_n = 1'b1; wstb_n = 1'b1;
        tick(8);
        check(exp_q.size() == 0, "R7 no pending", exp_q.size(), 0);
        check(dac_code == 14'h1FFF, "R7 same word", int'(dac_code), 'h1FFF);

        // R9: one strobe low at a time
        sel_n = 1'b0; bus_data = 14'h0555;
        tick(8);
        check(dac_code == 14'h1FFF, "R9 sel only", int'(dac_code), 'h1FFF);
        sel_n = 1'b1; wstb_n = 1'b0; bus_data = 14'h0666;
        tick(8);
        check(dac_code == 14'h1FFF, "R9 wstb only", int'(dac_code), 'h1FFF);
        wstb_n = 1'b1;
        tick(4);
        // R9: the stage still holds 0x1FFF; a fresh transfer strobe brings no change
        xfer_n = 1'b1;
        tick(4);
        xfer_n = 1'b0;
        tick(6);
        check(dac_code == 14'h1FFF, "R9 stage untouched", int'(dac_code), 'h1FFF);

        // Midscale (R8) via transfer strobe
        xfer_n = 1'b1;
        sel_n = 1'b0; wstb_n = 1'b0; bus_data = 14'h0000;
        tick(3);
        sel_n = 1'b1; wstb_n = 1'b1;
        tick(5);
        check(dac_code == 14'h1FFF, "R3 hold midscale", int'(dac_code), 'h1FFF);
        expect_word(14'h0000, "R8 midscale");
        xfer_n = 1'b0;
        tick(6);
        check(dac_code == 14'h0000, "R8 mid", int'(dac_code), 0);

        tick(6);
        check(exp_q.size() == 0, "R7 all pulses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule